// File: doc/BRIEF.md
# Inline Sample-Stream Run-Length Encoder

This block sits on the 32-bit sample path between a sampler and a capture memory. It has one word per cycle in and at most one word per cycle out, and every output is registered. When encoding is off, every input word is copied to the output one cycle later, all 32 bits included. When encoding is on, the top bit of the word is no longer a channel. It becomes a marker that separates sample words (marker 0) from count words (marker 1). The first word of a run goes out as a sample word. Later words whose channel bits equal it produce no output; they are only counted. When the value changes, a count word with the number of repeats goes out ahead of the new sample. A run of length one produces no count word. When a count reaches its ceiling, the block emits a count word at once and starts counting again, so one long run can produce several count words.

A narrow mode encodes only the low 16 channels, and bit 15 is the marker. The parameter `HI_COUNT` selects the count word layout in narrow mode. At its default of 1, the count sits in bits 31:16 and can reach 65535. At 0, the count sits in bits 14:0 and can reach 32767. An end-of-capture pulse flushes anything still held back, either a deferred sample or a partial count, and then parks the block in a final state until reset. `enc_en` and `narrow_mode` are expected to stay fixed during a capture. If either changes, the encoder restarts from its idle state and drops anything it was holding.

The controller has four states. ST_IDLE means no run is open. ST_RUN means the current run's sample has been emitted and its repeats are being counted. ST_PEND means a changed sample arrived in the same cycle its predecessor's count was emitted, so that sample is held and sent in the next free slot. ST_DONE is the final state. The transitions are as follows:
- IDLE→RUN on the first sample.
- RUN→RUN on a repeat, on a saturated count, or on a change after a run of one.
- RUN→PEND on a change after repeats.
- PEND→RUN when the held sample is emitted on a repeat or an idle cycle.
- PEND→PEND when another change arrives.
- Any state→DONE on end of capture.
- Any state→IDLE while disabled or on a configuration change.

Top module: `rle_encoder`

## Requirements
- R1: With `enc_en` low, each cycle's `in_valid`/`in_data` appear unchanged on `out_valid`/`out_data` one clock later, bit 31 included.
- R2: In wide mode with encoding on, the first word of each run is emitted as a sample word: bit 31 = 0 and bits 30:0 equal to the input's bits 30:0. Input bit 31 is discarded.
- R3: In wide mode, a valid input whose bits 30:0 equal those of the current run emits nothing, whatever its bit 31. On a change, a count word (bit 31 = 1, bits 30:0 = number of repeats) is emitted before the new run's sample word. Words come out in stream order, at most one per cycle, and idle input cycles never split a run.
- R4: A run of length one produces no count word, and a count word never carries zero.
- R5: In wide mode the count ceiling is 2^31−1. A count word is emitted as soon as a run's repeat tally reaches the ceiling, and counting then restarts from zero. No two count words are ever emitted back to back.
- R6: In narrow mode, sample words are 16'h0000, then a 0 at bit 15, then the input's bits 14:0. Input bits 31:15 are ignored when runs are compared.
- R7: In narrow mode with `HI_COUNT` = 1, a count word has the count in bits 31:16, 1 in bit 15 and zeros in bits 14:0. The ceiling is 65535, and longer runs are split as in R5.
- R8: An `end_capture` pulse emits the deferred sample or the partial count, if any, in the following cycle. In that same cycle `capture_done` rises, and it stays high until reset. The input word presented with the pulse, and all later inputs, produce no output.
- R9: After reset, `out_valid` and `capture_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_en | input | 1 | 1 = run-length encoding, 0 = pass-through |
| narrow_mode | input | 1 | 1 = encode the low 16 channels only |
| end_capture | input | 1 | One-cycle pulse that flushes and finishes the capture |
| in_valid | input | 1 | A sample is present on `in_data` |
| in_data | input | 32 | Sample word from the sampler |
| out_valid | output | 1 | `out_data` holds a word for memory |
| out_data | output | 32 | Sample, count or raw word |
| capture_done | output | 1 | Capture finished, block parked |

## Verification
On every cycle, assertions check the following: the one-cycle pass-through copy, the absence of zero-valued and back-to-back count words in wide mode, the counter never passing its ceiling, and the final state staying silent and sticky. Only the bench scenarios can show that the emitted stream decodes to the exact input. That covers the ordering of count and sample words across deferred samples and idle gaps, the split of a 65538-repeat run into 65535 plus 3, the masking of ignored channel bits in both modes, and what a flush emits from each state. The bench sweeps run-length pairs in both modes, with and without idle gaps, and compares the output against a stream built arithmetically from the run lengths.

// File: rtl/rle_enc_pkg.sv
package rle_enc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_PEND = 2'd2,
        ST_DONE = 2'd3
    } enc_state_t;

    typedef enum logic [1:0] {
        CNT_KEEP  = 2'd0,
        CNT_CLEAR = 2'd1,
        CNT_STEP  = 2'd2,
        CNT_FIRST = 2'd3
    } cnt_op_t;

    typedef enum logic [1:0] {
        EMIT_NONE   = 2'd0,
        EMIT_RAW    = 2'd1,
        EMIT_SAMPLE = 2'd2,
        EMIT_COUNT  = 2'd3
    } emit_t;

endpackage

// File: rtl/rle_key_cmp.sv
module rle_key_cmp #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_word,
    input  logic [W-1:0] b_word,
    input  logic         narrow,
    output logic         equal
);
    localparam int HALF = W / 2;

    logic [W-2:0] mask;
    logic [W-1:0] diff;

    always_comb begin
        mask  = narrow ? {{(W-HALF){1'b0}}, {(HALF-1){1'b1}}} : {(W-1){1'b1}};
        diff  = a_word ^ b_word;
        equal = ((diff[W-2:0] & mask) == '0);
    end
endmodule

// File: rtl/rle_run_counter.sv
module rle_run_counter
    import rle_enc_pkg::*;
#(
    parameter int W        = 32,
    parameter bit HI_COUNT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cnt_op_t       op,
    input  logic          narrow,
    output logic [W-2:0]  count,
    output logic [W-2:0]  limit,
    output logic          at_edge
);
    localparam int CW   = W - 1;
    localparam int HALF = W / 2;
    localparam logic [CW-1:0] LIM_WIDE   = {CW{1'b1}};
    localparam logic [CW-1:0] LIM_NARROW = HI_COUNT ? CW'((64'd1 << HALF) - 64'd1)
                                                    : CW'((64'd1 << (HALF-1)) - 64'd1);

    assign limit   = narrow ? LIM_NARROW : LIM_WIDE;
    assign at_edge = (count == limit - CW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            unique case (op)
                CNT_KEEP:  count <= count;
                CNT_CLEAR: count <= '0;
                CNT_STEP:  count <= count + CW'(1);
                CNT_FIRST: count <= CW'(1);
            endcase
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= limit);                                               // R5
endmodule

// File: rtl/rle_word_fmt.sv
module rle_word_fmt #(
    parameter int W        = 32,
    parameter bit HI_COUNT = 1'b1
) (
    input  logic         narrow,
    input  logic         as_count,
    input  logic [W-1:0] src_word,
    input  logic [W-2:0] cnt,
    output logic [W-1:0] word
);
    localparam int HALF = W / 2;

    logic [W-1:0] narrow_cnt;
    logic [W-1:0] wide_cnt;
    logic [W-1:0] narrow_smp;
    logic [W-1:0] wide_smp;

    generate
        if (HI_COUNT) begin : g_cnt_upper
            assign narrow_cnt = {cnt[HALF-1:0], 1'b1, {(HALF-1){1'b0}}};
        end else begin : g_cnt_lower
            assign narrow_cnt = {{HALF{1'b0}}, 1'b1, cnt[HALF-2:0]};
        end
    endgenerate

    assign wide_cnt   = {1'b1, cnt};
    assign wide_smp   = {1'b0, src_word[W-2:0]};
    assign narrow_smp = {{HALF{1'b0}}, 1'b0, src_word[HALF-2:0]};

    always_comb begin
        if (as_count) word = narrow ? narrow_cnt : wide_cnt;
        else          word = narrow ? narrow_smp : wide_smp;
    end
endmodule

// File: rtl/rle_encoder.sv
module rle_encoder
    import rle_enc_pkg::*;
#(
    parameter int W        = 32,
    parameter bit HI_COUNT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enc_en,
    input  logic         narrow_mode,
    input  logic         end_capture,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic         capture_done
);
    localparam int CW = W - 1;

    enc_state_t   state, state_nxt, state_eff;
    emit_t        emit;
    cnt_op_t      cnt_op;
    logic         hold_load;
    logic [W-1:0] hold_q;
    logic         en_q, narrow_q, cfg_changed;
    logic [CW-1:0] run_cnt, run_lim, cnt_src;
    logic         run_edge, keys_eq;
    logic [W-1:0] samp_src, samp_word, cnt_word;

    // Configuration tracking: any change restarts the encoder from idle.
    assign cfg_changed = (en_q != enc_en) || (narrow_q != narrow_mode);
    assign state_eff   = (state == ST_DONE) ? ST_DONE
                       : (cfg_changed ? ST_IDLE : state);
    assign capture_done = (state == ST_DONE);

    rle_key_cmp #(.W(W)) u_cmp (
        .a_word (in_data),
        .b_word (hold_q),
        .narrow (narrow_mode),
        .equal  (keys_eq)
    );

    rle_run_counter #(.W(W), .HI_COUNT(HI_COUNT)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (cnt_op),
        .narrow  (narrow_q),
        .count   (run_cnt),
        .limit   (run_lim),
        .at_edge (run_edge)
    );

    // Held sample goes out from PEND; otherwise the live input is the sample.
    assign samp_src = (state_eff == ST_PEND) ? hold_q : in_data;
    // A saturating repeat emits the ceiling value itself.
    assign cnt_src  = (state_eff == ST_RUN && !end_capture && in_valid && keys_eq && run_edge)
                    ? run_lim : run_cnt;

    rle_word_fmt #(.W(W), .HI_COUNT(HI_COUNT)) u_fmt_smp (
        .narrow   (narrow_mode),
        .as_count (1'b0),
        .src_word (samp_src),
        .cnt      (run_cnt),
        .word     (samp_word)
    );

    rle_word_fmt #(.W(W), .HI_COUNT(HI_COUNT)) u_fmt_cnt (
        .narrow   (narrow_mode),
        .as_count (1'b1),
        .src_word (in_data),
        .cnt      (cnt_src),
        .word     (cnt_word)
    );

    // Next-state and emission decision.
    always_comb begin
        state_nxt = state_eff;
        emit      = EMIT_NONE;
        cnt_op    = CNT_KEEP;
        hold_load = 1'b0;
        if (state_eff == ST_DONE) begin
            state_nxt = ST_DONE;
        end else if (!enc_en) begin
            cnt_op    = CNT_CLEAR;
            if (end_capture) begin
                state_nxt = ST_DONE;
            end else begin
                state_nxt = ST_IDLE;
                if (in_valid) emit = EMIT_RAW;
            end
        end else if (end_capture) begin
            state_nxt = ST_DONE;
            cnt_op    = CNT_CLEAR;
            if (state_eff == ST_PEND)                        emit = EMIT_SAMPLE;
            else if (state_eff == ST_RUN && run_cnt != '0)   emit = EMIT_COUNT;
        end else begin
            unique case (state_eff)
                ST_IDLE: begin
                    if (in_valid) begin
                        emit      = EMIT_SAMPLE;
                        hold_load = 1'b1;
                        cnt_op    = CNT_CLEAR;
                        state_nxt = ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (in_valid) begin
                        if (keys_eq) begin
                            if (run_edge) begin
                                emit   = EMIT_COUNT;
                                cnt_op = CNT_CLEAR;
                            end else begin
                                cnt_op = CNT_STEP;
                            end
                        end else if (run_cnt != '0) begin
                            emit      = EMIT_COUNT;
                            hold_load = 1'b1;
                            cnt_op    = CNT_CLEAR;
                            state_nxt = ST_PEND;
                        end else begin
                            emit      = EMIT_SAMPLE;
                            hold_load = 1'b1;
                        end
                    end
                end
                ST_PEND: begin
                    emit = EMIT_SAMPLE;
                    if (in_valid && keys_eq) begin
                        cnt_op    = CNT_FIRST;
                        state_nxt = ST_RUN;
                    end else if (in_valid) begin
                        hold_load = 1'b1;
                    end else begin
                        state_nxt = ST_RUN;
                    end
                end
                ST_DONE: state_nxt = ST_DONE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            hold_q   <= '0;
            en_q     <= 1'b0;
            narrow_q <= 1'b0;
        end else begin
            state    <= state_nxt;
            en_q     <= enc_en;
            narrow_q <= narrow_mode;
            if (hold_load) hold_q <= in_data;
        end
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= (emit != EMIT_NONE);
            unique case (emit)
                EMIT_NONE:   out_data <= out_data;
                EMIT_RAW:    out_data <= in_data;
                EMIT_SAMPLE: out_data <= samp_word;
                EMIT_COUNT:  out_data <= cnt_word;
            endcase
        end
    end

    AST_PASS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(enc_en) && !$past(end_capture) && !$past(capture_done))
        |-> (out_valid == $past(in_valid)) && (!out_valid || out_data == $past(in_data))); // R1

    AST_NO_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(enc_en) && !$past(narrow_mode) && out_valid && out_data[W-1])
        |-> (out_data[W-2:0] != '0));                                  // R4

    AST_NO_BACK2BACK_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(enc_en, 1) && $past(enc_en, 2) && !$past(narrow_mode, 1) && !$past(narrow_mode, 2)
         && $past(out_valid && out_data[W-1]))
        |-> !(out_valid && out_data[W-1]));                            // R5

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        capture_done |=> capture_done);                                // R8

    AST_DONE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_done && $past(capture_done)) |-> !out_valid);         // R8
endmodule

// File: tb/rle_encoder_bench.sv
module rle_encoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enc_en = 1'b0;
    logic        narrow_mode = 1'b0;
    logic        end_capture = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic [31:0] out_data;
    logic        capture_done;

    int n_chk  = 0;
    int n_fail = 0;
    bit reported = 1'b0;
    logic [31:0] exp_q[$];
    logic [31:0] got_q[$];

    always #4 clk = ~clk;   // 125 MHz

    rle_encoder u_rle_encoder (
        .clk          (clk),
        .rst_n        (rst_n),
        .enc_en       (enc_en),
        .narrow_mode  (narrow_mode),
        .end_capture  (end_capture),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .out_valid    (out_valid),
        .out_data     (out_data),
        .capture_done (capture_done)
    );

    always @(negedge clk) if (rst_n && out_valid) got_q.push_back(out_data);

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        end
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] smp_w(input bit m16, input logic [31:0] v);
        return m16 ? {16'h0000, 1'b0, v[14:0]} : {1'b0, v[30:0]};
    endfunction

    function automatic logic [31:0] cnt_w(input bit m16, input logic [31:0] n);
        return m16 ? {n[15:0], 1'b1, 15'h0000} : {1'b1, n[30:0]};
    endfunction

    task automatic drive(input logic v, input logic [31:0] d);
        in_valid = v;
        in_data  = d;
        @(negedge clk);
    endtask

    task automatic do_reset(input bit en, input bit m16);
        rst_n = 1'b0; in_valid = 1'b0; end_capture = 1'b0;
        enc_en = en; narrow_mode = m16;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !capture_done, "R9 reset state", {30'h0, out_valid, capture_done}, 32'h0);
        exp_q.delete();
        got_q.delete();
    endtask

    // Expected count words for a run with reps repeats (R5/R7 split rule).
    task automatic push_counts(input bit m16, input int unsigned reps);
        int unsigned lim = m16 ? 32'd65535 : 32'h7FFF_FFFF;
        int unsigned r = reps;
        while (r >= lim) begin
            exp_q.push_back(cnt_w(m16, lim));
            r -= lim;
        end
        if (r > 0) exp_q.push_back(cnt_w(m16, r));
    endtask

    // One run: ignored channel bits vary within it (R3/R6).
    task automatic send_run(input bit m16, input logic [31:0] key, input int len, input bit gap);
        exp_q.push_back(smp_w(m16, key));
        for (int i = 0; i < len; i++) begin
            logic [31:0] noise;
            noise = m16 ? ((i * 32'h0001_2345) << 15) : {i[0], 31'h0};
            drive(1'b1, key ^ noise);
            if (gap) drive(1'b0, 32'hDEAD_BEEF);
        end
        push_counts(m16, len - 1);
    endtask

    task automatic compare(input string req);
        chk(got_q.size() == exp_q.size(), req, got_q.size(), exp_q.size());
        for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
            chk(got_q[i] === exp_q[i], req, got_q[i], exp_q[i]);
        exp_q.delete();
        got_q.delete();
    endtask

    // Flush with a live word alongside (ignored), then junk after done (R8).
    task automatic flush_and_compare(input string req);
        in_valid = 1'b1; in_data = 32'h5A5A_5A5A; end_capture = 1'b1;
        @(negedge clk);
        end_capture = 1'b0;
        chk(capture_done, "R8 done after flush", {31'h0, capture_done}, 32'h1);
        for (int i = 0; i < 4; i++) drive(1'b1, 32'h0000_0777 + i);
        drive(1'b0, 32'h0);
        chk(capture_done, "R8 done sticky", {31'h0, capture_done}, 32'h1);
        compare(req);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        // R1: pass-through, full 32 bits, one-cycle latency.
        do_reset(1'b0, 1'b0);
        for (int i = 0; i < 40; i++) begin
            logic [31:0] v;
            logic        vl;
            v  = i * 32'h9E37_79B9;
            vl = (i % 5) != 3;
            drive(vl, v);
            if (vl) exp_q.push_back(v);
            chk(out_valid == vl, "R1 latency", {31'h0, out_valid}, {31'h0, vl});
        end
        drive(1'b0, 32'h0);
        compare("R1 pass stream");

        // R2/R3/R4: wide-mode sweep of run-length pairs, with and without gaps.
        for (int l1 = 1; l1 <= 5; l1++)
            for (int l2 = 1; l2 <= 5; l2++)
                for (int g = 0; g < 2; g++) begin
                    do_reset(1'b1, 1'b0);
                    for (int r = 0; r < 4; r++)
                        send_run(1'b0, 32'h0000_1000 + l1 * 64 + l2 * 8 + r,
                                 (r % 2 == 0) ? l1 : l2, g[0]);
                    flush_and_compare("R2 R3 R4 wide sweep");
                end

        // R6/R7: narrow-mode sweep, upper bits vary within runs.
        for (int l1 = 1; l1 <= 4; l1++)
            for (int l2 = 1; l2 <= 4; l2++) begin
                do_reset(1'b1, 1'b1);
                for (int r = 0; r < 3; r++)
                    send_run(1'b1, 32'h0000_0200 + l1 * 32 + l2 * 4 + r,
                             (r % 2 == 0) ? l1 : l2, 1'b0);
                flush_and_compare("R6 R7 narrow sweep");
            end

        // R3: long wide run, no saturation.
        do_reset(1'b1, 1'b0);
        send_run(1'b0, 32'h1234_5678, 300, 1'b0);
        send_run(1'b0, 32'h0000_0042, 1, 1'b0);
        flush_and_compare("R3 long wide run");

        // R7: narrow saturation and split (65538 repeats -> 65535 + 3, then exact ceiling).
        do_reset(1'b1, 1'b1);
        send_run(1'b1, 32'h0000_0101, 65539, 1'b0);
        send_run(1'b1, 32'h0000_0202, 65536, 1'b0);
        send_run(1'b1, 32'h0000_0303, 2, 1'b0);
        flush_and_compare("R7 narrow ceiling split");

        // R8: flush with a deferred sample (run of 3 then a change).
        do_reset(1'b1, 1'b0);
        send_run(1'b0, 32'h0000_0011, 3, 1'b0);
        send_run(1'b0, 32'h0000_0022, 1, 1'b0);
        flush_and_compare("R8 flush deferred sample");

        report();
        $finish;
    end
endmodule